// File: doc/BRIEF.md
# Programmable Watchdog Timer Unit

This block is a watchdog timer that sits behind a single byte-wide control register. Software programs a countdown interval as a 5-bit multiplier and a 2-bit resolution code. It also sets one steering bit that picks what happens when the count runs out. The countdown advances only on an externally supplied 16 Hz tick enable, so one count step is one sixteenth of a second. Both a write and a read of the register restart the countdown, so software can service the watchdog with either access.

When the count reaches its end, the block raises an expired flag. In interrupt mode it then emits a one-cycle interrupt pulse and goes idle until the next restart. In reset mode it emits a one-cycle system reset request and clears the control register, which leaves the watchdog disabled. The register access strobes are plain single-cycle enables with no back-pressure. Read data is the stored register value and is always valid. Bus decoding, timebase generation and interrupt routing belong to the surrounding logic.

Top module: `wdog_unit`

## Requirements
- R1: The control byte encodes the resolution code in bits 1:0 and the multiplier in bits 6:2. The countdown length is multiplier × 4^resolution ticks, and the expiry outputs react to the last of those ticks.
- R2: When the programmed interval is zero (multiplier field 0, including a control byte of 0x00), no expiry ever occurs, whatever ticks arrive.
- R3: A write strobe stores the write data as the control byte, visible on the read data port from the next cycle. It also restarts the countdown with the interval of the new value.
- R4: A read strobe restarts the countdown with the interval of the stored value and leaves the stored value unchanged. The read data port always shows the stored value.
- R5: Every restart (write or read) clears the expired flag on the next cycle. Every expiry sets it on the cycle after the final tick.
- R6: With control bit 7 at 0, an expiry produces a single-cycle interrupt pulse and no reset request. The counter then stays idle until the next restart, with no further pulses.
- R7: With control bit 7 at 1, an expiry produces a single-cycle reset request and no interrupt. In the same cycle the control byte reads back as 0x00.
- R8: A restart in the same cycle as a tick takes precedence, so that tick is not counted. When write and read strobes coincide, the write data is what gets stored.
- R9: A synchronous reset clears the control byte, the expired flag, the countdown and both pulse outputs.
- R10: Cycles without the tick enable never advance the countdown and never produce an expiry pulse on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 16 Hz count enable, one clock wide per step |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Control register read strobe (restarts the count) |
| reg_wdata | input | 8 | Write data for the control register |
| reg_rdata | output | 8 | Stored control register value |
| expired_o | output | 1 | Expiry flag, set by expiry, cleared by restart |
| irq_o | output | 1 | One-cycle interrupt pulse on expiry in interrupt mode |
| rst_req_o | output | 1 | One-cycle system reset request on expiry in reset mode |

## Verification
The bench aims at off-by-one interval lengths. A design that counted one tick too many or too few would pulse a cycle early or late against the exact tick count for codes such as 0x0D (12 ticks) and 0x07 (64 ticks). It also covers zero multipliers with nonzero resolution or steering bits. A design that treated those as "very short" instead of disabled would fire spuriously. Coincident restart-and-tick and coincident write-and-read cycles are driven on purpose, so that a wrong priority shows up as an early expiry or a wrong stored byte. Reset-mode expiry is checked for the register clearing, and interrupt-mode expiry for the absence of a second pulse while ticks keep arriving.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int MULT_BITS = 5;
  localparam int RES_BITS  = 2;
  localparam int CTRL_BITS = 1 + MULT_BITS + RES_BITS;

  typedef struct packed {
    logic                 to_reset;
    logic [MULT_BITS-1:0] mult;
    logic [RES_BITS-1:0]  res;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_span.sv
module wdt_span #(
  parameter int MULT_W = 5,
  parameter int RES_W  = 2,
  parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
  input  logic [MULT_W-1:0] mult,
  input  logic [RES_W-1:0]  res,
  output logic [CNT_W-1:0]  span
);
  localparam int NRES = 1 << RES_W;

  logic [CNT_W-1:0] scaled [NRES];

  // each resolution step multiplies by four
  for (genvar g = 0; g < NRES; g++) begin : g_scale
    assign scaled[g] = CNT_W'(mult) << (2 * g);
  end

  assign span = scaled[res];
endmodule

// File: rtl/wdt_down.sv
module wdt_down #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= |load_val;
    end else if (run_q && tick) begin
      if (cnt_q == CNT_W'(1)) begin
        cnt_q <= '0;
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign done = run_q && tick && !load && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/wdog_unit.sv
module wdog_unit
  import wdt_pkg::*;
#(
  parameter int MULT_W = MULT_BITS,
  parameter int RES_W  = RES_BITS,
  parameter int REG_W  = 1 + MULT_W + RES_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             expired_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  localparam int CNT_W   = MULT_W + 2 * ((1 << RES_W) - 1);
  localparam int STEER_B = REG_W - 1;

  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] next_ctrl;
  logic [CNT_W-1:0] span;
  logic             restart;
  logic             done;
  logic             flag_q;
  logic             irq_q;
  logic             rreq_q;

  assign restart   = reg_wr || reg_rd;
  assign next_ctrl = reg_wr ? reg_wdata : ctrl_q;

  wdt_span #(.MULT_W(MULT_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_span (
    .mult (next_ctrl[RES_W +: MULT_W]),
    .res  (next_ctrl[RES_W-1:0]),
    .span (span)
  );

  wdt_down #(.CNT_W(CNT_W)) u_down (
    .clk      (clk),
    .rst      (rst),
    .load     (restart),
    .load_val (span),
    .tick     (tick),
    .done     (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      irq_q  <= done && !ctrl_q[STEER_B];
      rreq_q <= done && ctrl_q[STEER_B];
      if (reg_wr)
        ctrl_q <= reg_wdata;
      else if (done && ctrl_q[STEER_B])
        ctrl_q <= '0;
      if (restart)
        flag_q <= 1'b0;
      else if (done)
        flag_q <= 1'b1;
    end
  end

  assign reg_rdata = ctrl_q;
  assign expired_o = flag_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rreq_q;
endmodule

// File: rtl/wdog_unit_chk.sv
module wdog_unit_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             expired_o,
  input logic             irq_o,
  input logic             rst_req_o
);
  a_r6_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  a_r7_rreq_single: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);

  a_r7_ctrl_cleared: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> (reg_rdata == '0));

  a_r6_one_action: assert property (@(posedge clk) disable iff (rst)
    !(irq_o && rst_req_o));

  a_r5_flag_on_expiry: assert property (@(posedge clk) disable iff (rst)
    (irq_o || rst_req_o) |-> expired_o);

  a_r5_restart_clears: assert property (@(posedge clk) disable iff (rst)
    (reg_wr || reg_rd) |=> !expired_o);

  a_r3_write_stores: assert property (@(posedge clk) disable iff (rst)
    reg_wr |=> (reg_rdata == $past(reg_wdata)));

  a_r10_no_tick_no_pulse: assert property (@(posedge clk) disable iff (rst)
    !tick |=> !(irq_o || rst_req_o));
endmodule

bind wdog_unit wdog_unit_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .expired_o (expired_o),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o)
);

// File: tb/wdog_unit_test.sv
module wdog_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       expired_o;
  logic       irq_o;
  logic       rst_req_o;

  int checks = 0;
  int failures = 0;

  // reference state
  logic [7:0] m_ctrl = '0;
  int         m_cnt  = 0;
  bit         m_run  = 0;
  bit         m_flag = 0;
  bit         m_irq  = 0;
  bit         m_rreq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_unit uut (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .expired_o (expired_o),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  // R1: multiplier in bits 6:2 times four to the power of bits 1:0
  function automatic int span_of(input logic [7:0] v);
    return int'(v[6:2]) * (1 << (2 * int'(v[1:0])));
  endfunction

  task automatic check(input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit rs, input bit wr, input bit rd,
                            input logic [7:0] d, input bit tk);
    m_irq  = 0;
    m_rreq = 0;
    if (rs) begin
      m_ctrl = '0; m_cnt = 0; m_run = 0; m_flag = 0;
    end else if (wr) begin
      m_ctrl = d; m_cnt = span_of(d); m_run = (m_cnt != 0); m_flag = 0;
    end else if (rd) begin
      m_cnt = span_of(m_ctrl); m_run = (m_cnt != 0); m_flag = 0;
    end else if (m_run && tk) begin
      if (m_cnt == 1) begin
        m_cnt = 0; m_run = 0; m_flag = 1;
        if (m_ctrl[7]) begin
          m_rreq = 1; m_ctrl = '0;
        end else begin
          m_irq = 1;
        end
      end else begin
        m_cnt--;
      end
    end
  endtask

  task automatic step(input string tag, input bit rs, input bit wr, input bit rd,
                      input logic [7:0] d, input bit tk);
    @(negedge clk);
    rst = rs; reg_wr = wr; reg_rd = rd; reg_wdata = d; tick = tk;
    @(posedge clk);
    model_step(rs, wr, rd, d, tk);
    #(CLK_PERIOD/4);
    check(tag, "rdata",   int'(reg_rdata), int'(m_ctrl));
    check(tag, "expired", int'(expired_o), int'(m_flag));
    check(tag, "irq",     int'(irq_o),     int'(m_irq));
    check(tag, "rst_req", int'(rst_req_o), int'(m_rreq));
  endtask

  task automatic idle(input string tag, input int n, input bit tk);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 8'h00, tk);
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    failures++;
    $display("FAIL watchdog expired, expected end of run");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R9: reset state
    for (int i = 0; i < 3; i++) step("R9", 1, 0, 0, 8'hFF, 1);

    // R3, R1: 0x0D -> M=3, R=1 -> 12 ticks; pulse exactly after the 12th
    step("R3", 0, 1, 0, 8'h0D, 0);
    idle("R1", 11, 1);
    check("R1", "irq_early", int'(irq_o), 0);
    step("R6", 0, 0, 0, 8'h00, 1);
    check("R6", "irq_on_12th", int'(irq_o), 1);
    idle("R6", 20, 1);

    // R4, R5: read restarts with stored value and clears the flag
    check("R5", "flag_set", int'(expired_o), 1);
    step("R4", 0, 0, 1, 8'hAA, 0);
    check("R4", "rdata_kept", int'(reg_rdata), 8'h0D);
    check("R5", "flag_clear", int'(expired_o), 0);
    idle("R10", 30, 0);
    idle("R4", 12, 1);
    check("R4", "irq_after_read", int'(irq_o), 1);

    // R2: zero multiplier disables even with other bits set
    step("R2", 0, 1, 0, 8'h83, 0);
    idle("R2", 60, 1);
    step("R2", 0, 1, 0, 8'h00, 0);
    idle("R2", 20, 1);
    check("R2", "no_expiry", int'(expired_o), 0);

    // R7: reset mode, one tick interval
    step("R7", 0, 1, 0, 8'h84, 0);
    step("R7", 0, 0, 0, 8'h00, 1);
    check("R7", "rreq", int'(rst_req_o), 1);
    check("R7", "ctrl_zero", int'(reg_rdata), 0);
    idle("R7", 10, 1);

    // R8: restart coincident with final tick wins
    step("R8", 0, 1, 0, 8'h04, 0);
    step("R8", 0, 0, 1, 8'h00, 1);
    check("R8", "no_expiry", int'(expired_o), 0);
    step("R8", 0, 1, 1, 8'h58, 1);
    check("R8", "write_wins", int'(reg_rdata), 8'h58);

    // R1: largest resolution, M=1 R=3 -> 64 ticks
    step("R1", 0, 1, 0, 8'h07, 0);
    idle("R1", 63, 1);
    check("R1", "no_irq_63", int'(irq_o), 0);
    step("R1", 0, 0, 0, 8'h00, 1);
    check("R1", "irq_64", int'(irq_o), 1);

    // R9: reset in the middle of a count
    step("R9", 0, 1, 0, 8'h89, 0);
    idle("R9", 5, 1);
    step("R9", 1, 0, 0, 8'h00, 1);
    idle("R9", 40, 1);

    // random mix
    for (int i = 0; i < 20000; i++) begin
      logic [7:0] d;
      int r;
      bit wr, rd;
      r  = int'($urandom_range(0, 99));
      wr = (r < 2);
      rd = (r >= 2 && r < 4);
      d  = 8'($urandom);
      if ($urandom_range(0, 3) != 0) d[6:4] = 3'b000;
      step("R1", (r == 99), wr, rd, d, 1'($urandom_range(0, 1)));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule